// File: doc/BRIEF.md
# In-Band Loop-Back Code Detector

The block watches the received bit stream of a T1 line and reports whether a repeating in-band loop-back code is present. Two such codes exist: a loop-up request, which repeats `00001`, and a loop-down request, which repeats `001`. A code counts as present only after it has run for longer than a qualification time with few bit errors. After that, the status stays up until the error rate over one measurement window gets too high. When the framer reports alignment, the framing bit at the start of each frame is skipped, so an in-band code sent in the payload is not disturbed by it. A second mode uses the same status bit to show whether a pseudo-random test sequence (x^15 + x^14 + 1) has locked.

Three checkers run in parallel on every evaluated bit: loop-up, loop-down and pseudo-random. Each one counts errors over fixed windows of evaluated bits. Two inputs pick which checker's verdict drives the registered status output. Every change of that output, including a change caused by the select inputs, raises a one-cycle change pulse. The integrating logic uses this pulse as an interrupt.

Top module: `lbc_detect`

## Requirements
- R1: A synchronous active-low reset clears `lb_status`, `lb_irq`, every counter and the bit history. The reset itself raises no `lb_irq` pulse.
- R2: With `prbs_mode`=0 and `code_sel`=0, `lb_status` rises once a run of `QUAL_BITS/WIN_BITS+1` consecutive good windows completes against the loop-up code (`00001` repeated). A window is `WIN_BITS` evaluated bits, and it is good when it holds at most `ERR_MAX` errors.
- R3: With `prbs_mode`=0 and `code_sel`=1, the same qualification applies against the loop-down code (`001` repeated).
- R4: For a code of period P, an evaluated bit is an error when it differs from the evaluated bit P positions earlier. It is also an error when the last P evaluated bits, the current one included, do not hold exactly one `1`. The history starts at all zeros.
- R5: A window with more than `ERR_MAX` errors restarts the count of good windows. If the status is set, the status clears when that window completes.
- R6: Once set, the status holds through any number of windows with at most `ERR_MAX` errors.
- R7: When `rx_en`, `frm_start` and `frm_lock` are all 1, the bit is not evaluated: it adds no error, it does not advance the window and it does not enter the history. When `frm_lock` is 0, the frame-start bit is evaluated like any other bit.
- R8: A cycle with `rx_en`=0 has no effect on any checker, whatever `rx_bit` carries.
- R9: `lb_irq` is 1 for exactly the cycle after each clock edge at which `lb_status` changed value, whether it rose or fell. This includes changes caused by `prbs_mode` or `code_sel`.
- R10: With `prbs_mode`=1, an evaluated bit is an error when it differs from the XOR of the bits 14 and 15 positions earlier. One good window sets the status.
- R11: In the pseudo-random mode, an all-ones stream and an all-zeros stream both count as error-free. A bit that is 1 while the previous bit and the bits 14 and 15 earlier are also 1 is never an error.
- R12: A checker's verdict takes effect at the clock edge that samples the last bit of the deciding window. `lb_status` shows it one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_bit | input | 1 | Received data bit |
| rx_en | input | 1 | Qualifies `rx_bit` for this cycle |
| frm_start | input | 1 | Marks the first bit of a frame |
| frm_lock | input | 1 | Framer reports alignment |
| prbs_mode | input | 1 | 1 selects pseudo-random lock reporting |
| code_sel | input | 1 | 0 selects loop-up, 1 selects loop-down |
| lb_status | output | 1 | Qualified detection or lock status |
| lb_irq | output | 1 | One-cycle pulse on each status change |

## Verification
A checker's verdict is decided at the edge that samples the last bit of a window. `lb_status` and `lb_irq` follow exactly one edge after that. A change of `prbs_mode` or `code_sel` shows up on both outputs one edge after the edge that samples it.

The bench drives inputs on the falling edge. Its behavioural model advances on the same rising edge as the design. Both outputs are compared with the model at every following falling edge, so each result is checked in the cycle it is due. Explicit checks after each phase wait a few idle cycles first, so that the last window decision has reached the outputs.

// File: rtl/lbc_pkg.sv
// Shared constants for the loop-back code detector.
// Assumes: detector indices are used both as generate index and mux select.
package lbc_pkg;
    localparam int DET_ACT    = 0;   // loop-up code checker
    localparam int DET_DEACT  = 1;   // loop-down code checker
    localparam int DET_PRBS   = 2;   // pseudo-random lock checker
    localparam int NUM_DET    = 3;

    localparam int ACT_PERIOD   = 5; // 00001 repeated
    localparam int DEACT_PERIOD = 3; // 001 repeated
    localparam int PRBS_TAP_A   = 14;
    localparam int PRBS_TAP_B   = 15;

    // history length each checker needs
    function automatic int hist_len(input int kind);
        if (kind == DET_PRBS) return PRBS_TAP_B;
        if (kind == DET_ACT)  return ACT_PERIOD;
        return DEACT_PERIOD;
    endfunction
endpackage

// File: rtl/lbc_err_gen.sv
// Per-bit error generator. Keeps a history of evaluated bits and flags
// whether the current bit breaks the expected sequence.
// Code kinds: the bit must equal the bit one period earlier, and the last
// period's worth of bits must hold exactly one mark.
// PRBS kind: the bit must equal tap14 XOR tap15, and an all-ones run is
// also accepted.
// Assumes: err_o is only meaningful while eval_i is high.
module lbc_err_gen
    import lbc_pkg::*;
#(
    parameter int KIND = DET_ACT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eval_i,
    input  logic bit_i,
    output logic err_o
);
    localparam int HW = hist_len(KIND);

    logic [HW-1:0] hist;   // hist[0] is the most recent evaluated bit

    // shift evaluated bits into the history
    always_ff @(posedge clk) begin
        if (!rst_n)      hist <= '0;
        else if (eval_i) hist <= {hist[HW-2:0], bit_i};
    end

    generate
        if (KIND == DET_PRBS) begin : g_prbs
            logic pred, ones_run;
            // predicted bit and all-ones run acceptance
            always_comb begin
                pred     = hist[PRBS_TAP_A-1] ^ hist[PRBS_TAP_B-1];
                ones_run = bit_i & hist[0] & hist[PRBS_TAP_A-1] & hist[PRBS_TAP_B-1];
                err_o    = (bit_i != pred) && !ones_run;
            end
        end else begin : g_code
            logic [HW-1:0] recent;
            // periodic match plus single-mark shape test
            always_comb begin
                recent = {hist[HW-2:0], bit_i};
                err_o  = (bit_i != hist[HW-1]) || ($countones(recent) != 1);
            end
        end
    endgenerate
endmodule

// File: rtl/lbc_ber_qual.sv
// Error-rate qualifier. Counts errors over windows of WIN_BITS evaluated
// bits. QUAL_WINS consecutive good windows set the status, and any bad
// window clears it and restarts the run.
// Assumes: err_i is valid whenever eval_i is high.
module lbc_ber_qual #(
    parameter int WIN_BITS  = 1000,
    parameter int ERR_MAX   = 10,
    parameter int QUAL_WINS = 52
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eval_i,
    input  logic err_i,
    output logic status_o
);
    localparam int WCW = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;
    localparam int ECW = $clog2(WIN_BITS + 1);
    localparam int QCW = $clog2(QUAL_WINS + 1);

    logic [WCW-1:0] win_cnt;
    logic [ECW-1:0] err_cnt;
    logic [ECW-1:0] err_sum;
    logic [QCW-1:0] good_wins;
    logic           win_last;
    logic           win_good;

    // window end and verdict for the current bit
    always_comb begin
        err_sum  = err_cnt + ECW'(err_i);
        win_last = eval_i && (win_cnt == WCW'(WIN_BITS - 1));
        win_good = (err_sum <= ECW'(ERR_MAX));
    end

    // window position and error tally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_cnt <= '0;
            err_cnt <= '0;
        end else if (win_last) begin
            win_cnt <= '0;
            err_cnt <= '0;
        end else if (eval_i) begin
            win_cnt <= win_cnt + 1'b1;
            err_cnt <= err_sum;
        end
    end

    // good-window run and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_wins <= '0;
            status_o  <= 1'b0;
        end else if (win_last) begin
            if (!win_good) begin
                good_wins <= '0;
                status_o  <= 1'b0;
            end else if (!status_o) begin
                if (good_wins == QCW'(QUAL_WINS - 1)) begin
                    good_wins <= '0;
                    status_o  <= 1'b1;
                end else begin
                    good_wins <= good_wins + 1'b1;
                end
            end
        end
    end

    // window counter never reaches the window length (R5)
    assert_win_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_cnt < WCW'(WIN_BITS));

    // status rises only when a window completes (R12)
    assert_rise_at_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o) |-> $past(win_last));

    // status falls only when a window completes (R5)
    assert_fall_at_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(status_o)) |-> $past(win_last));
endmodule

// File: rtl/lbc_detect.sv
// Loop-back code detector top. Runs the loop-up, loop-down and PRBS
// checkers in parallel on every evaluated bit. The select inputs pick one
// verdict, which is registered onto lb_status, and each change of it
// raises lb_irq for one cycle.
// Assumes: frm_start marks frame bit positions in the rx_en stream.
module lbc_detect
    import lbc_pkg::*;
#(
    parameter int QUAL_BITS = 51200,
    parameter int WIN_BITS  = 1000,
    parameter int ERR_MAX   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_en,
    input  logic frm_start,
    input  logic frm_lock,
    input  logic prbs_mode,
    input  logic code_sel,
    output logic lb_status,
    output logic lb_irq
);
    localparam int QUAL_WINS = QUAL_BITS / WIN_BITS + 1;

    logic                eval;
    logic [NUM_DET-1:0]  det_err;
    logic [NUM_DET-1:0]  det_stat;
    logic                sel_stat;

    // skip framing positions while aligned
    always_comb eval = rx_en && !(frm_start && frm_lock);

    generate
        for (genvar g = 0; g < NUM_DET; g++) begin : g_det
            localparam int QW = (g == DET_PRBS) ? 1 : QUAL_WINS;

            lbc_err_gen #(.KIND(g)) u_err (
                .clk    (clk),
                .rst_n  (rst_n),
                .eval_i (eval),
                .bit_i  (rx_bit),
                .err_o  (det_err[g])
            );

            lbc_ber_qual #(
                .WIN_BITS  (WIN_BITS),
                .ERR_MAX   (ERR_MAX),
                .QUAL_WINS (QW)
            ) u_qual (
                .clk      (clk),
                .rst_n    (rst_n),
                .eval_i   (eval),
                .err_i    (det_err[g]),
                .status_o (det_stat[g])
            );
        end
    endgenerate

    // pick the verdict requested by the mode inputs
    always_comb begin
        if (prbs_mode)     sel_stat = det_stat[DET_PRBS];
        else if (code_sel) sel_stat = det_stat[DET_DEACT];
        else               sel_stat = det_stat[DET_ACT];
    end

    // register status and flag its changes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lb_status <= 1'b0;
            lb_irq    <= 1'b0;
        end else begin
            lb_status <= sel_stat;
            lb_irq    <= (sel_stat != lb_status);
        end
    end

    // pulse only accompanies a real change (R9)
    assert_irq_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lb_irq |-> (lb_status != $past(lb_status)));

    // every change outside reset is flagged (R9)
    assert_change_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (lb_status != $past(lb_status))) |-> lb_irq);

    // the pulse is never longer than one cycle (R9)
    assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lb_irq |=> !lb_irq || (lb_status != $past(lb_status)));
endmodule

// File: tb/tb_lbc_detect.sv
`timescale 1ns/1ps
module tb_lbc_detect;
    localparam int QB = 400;
    localparam int WB = 50;
    localparam int EM = 4;
    localparam int QW = QB / WB + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0, rx_en = 1'b0, frm_start = 1'b0, frm_lock = 1'b0;
    logic prbs_mode = 1'b0, code_sel = 1'b0;
    logic lb_status, lb_irq;

    int nchk = 0, nfail = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    lbc_detect #(.QUAL_BITS(QB), .WIN_BITS(WB), .ERR_MAX(EM)) dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_en(rx_en),
        .frm_start(frm_start), .frm_lock(frm_lock), .prbs_mode(prbs_mode),
        .code_sel(code_sel), .lb_status(lb_status), .lb_irq(lb_irq)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    bit hq[0:14];
    int wc[3], ec[3], gw[3];
    bit st[3];
    bit m_stat = 1'b0, m_irq = 1'b0;

    function automatic bit kerr(input int k, input bit b);
        int p, ones;
        if (k == 2) return (b != (hq[13] ^ hq[14])) && !(b && hq[0] && hq[13] && hq[14]);
        p = (k == 0) ? 5 : 3;
        ones = int'(b);
        for (int i = 0; i < p - 1; i++) ones += int'(hq[i]);
        return (b != hq[p-1]) || (ones != 1);
    endfunction

    always @(posedge clk) begin : model
        bit nsel;
        int es;
        if (!rst_n) begin
            for (int i = 0; i < 15; i++) hq[i] = 1'b0;
            for (int k = 0; k < 3; k++) begin wc[k] = 0; ec[k] = 0; gw[k] = 0; st[k] = 1'b0; end
            m_stat = 1'b0; m_irq = 1'b0;
        end else begin
            nsel = prbs_mode ? st[2] : (code_sel ? st[1] : st[0]);
            m_irq = (nsel != m_stat);
            m_stat = nsel;
            if (rx_en && !(frm_start && frm_lock)) begin
                for (int k = 0; k < 3; k++) begin
                    es = ec[k] + int'(kerr(k, rx_bit));
                    if (wc[k] == WB - 1) begin
                        wc[k] = 0; ec[k] = 0;
                        if (es > EM) begin st[k] = 1'b0; gw[k] = 0; end
                        else if (!st[k]) begin
                            if (gw[k] >= ((k == 2) ? 1 : QW) - 1) begin st[k] = 1'b1; gw[k] = 0; end
                            else gw[k]++;
                        end
                    end else begin
                        wc[k]++; ec[k] = es;
                    end
                end
                for (int i = 14; i > 0; i--) hq[i] = hq[i-1];
                hq[0] = rx_bit;
            end
        end
    end

    // per-cycle comparison at the falling edge, then drive new inputs
    task automatic tick(input bit b, input bit en, input bit fs);
        @(negedge clk);
        if (cmp_on) begin
            nchk++;
            if (lb_status !== m_stat || lb_irq !== m_irq) begin
                nfail++;
                $display("FAIL %s: status/irq actual %b/%b expected %b/%b at %0t",
                         cur_req, lb_status, lb_irq, m_stat, m_irq, $time);
            end
        end
        rx_bit = b; rx_en = en; frm_start = fs;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // repeated code of period p, optional flip every flip_ev bits
    task automatic send_code(input int p, input int n, input int flip_ev);
        for (int i = 0; i < n; i++) begin
            bit b;
            b = ((i % p) == p - 1);
            if (flip_ev > 0 && (i % flip_ev) == flip_ev - 1) b = ~b;
            tick(b, 1'b1, 1'b0);
        end
    endtask

    // code with a junk '1' framing bit before every fs_ev code bits
    task automatic send_framed(input int p, input int n, input int fs_ev);
        for (int i = 0; i < n; i++) begin
            if (i % fs_ev == 0) tick(1'b1, 1'b1, 1'b1);
            tick(((i % p) == p - 1), 1'b1, 1'b0);
        end
    endtask

    logic [14:0] lfsr = 15'h1ACE;
    task automatic send_prbs(input int n);
        for (int i = 0; i < n; i++) begin
            bit b;
            b = lfsr[14] ^ lfsr[13];
            lfsr = {lfsr[13:0], b};
            tick(b, 1'b1, 1'b0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state
        idle(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        idle(2);
        chk("R1 status", lb_status, 1'b0);
        chk("R1 irq", lb_irq, 1'b0);

        // R2 R12: loop-up code qualifies
        cur_req = "R2 R12";
        send_code(5, 600, 0);
        idle(3);
        chk("R2", lb_status, 1'b1);

        // R9: select change drops status with a one-cycle pulse
        cur_req = "R9";
        code_sel = 1'b1;
        tick(1'b0, 1'b0, 1'b0);
        chk("R9 status", lb_status, 1'b0);
        chk("R9 irq", lb_irq, 1'b1);
        tick(1'b0, 1'b0, 1'b0);
        chk("R9 irq end", lb_irq, 1'b0);

        // R3: loop-down code qualifies
        cur_req = "R3";
        send_code(3, 750, 0);
        idle(3);
        chk("R3", lb_status, 1'b1);

        // R4 R6: sparse flips keep status
        cur_req = "R4 R6";
        send_code(3, 600, 60);
        idle(3);
        chk("R6", lb_status, 1'b1);

        // R5: dense errors clear status
        cur_req = "R5";
        send_code(3, 150, 5);
        idle(3);
        chk("R5", lb_status, 1'b0);

        // R8: disabled cycles carry junk and are ignored
        cur_req = "R8";
        for (int i = 0; i < 750; i++) begin
            tick(((i % 3) == 2), 1'b1, 1'b0);
            tick(1'($urandom), 1'b0, 1'($urandom));
        end
        idle(3);
        chk("R8", lb_status, 1'b1);

        // R1: reset while set, no pulse
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        tick(1'b0, 1'b0, 1'b0);
        chk("R1 reset status", lb_status, 1'b0);
        chk("R1 reset irq", lb_irq, 1'b0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 after reset irq", lb_irq, 1'b0);

        // R7: framing bits skipped while aligned
        cur_req = "R7";
        code_sel = 1'b0;
        frm_lock = 1'b1;
        send_framed(5, 700, 40);
        idle(3);
        chk("R7 locked", lb_status, 1'b1);
        frm_lock = 1'b0;
        send_framed(5, 300, 20);
        idle(3);
        chk("R7 unlocked", lb_status, 1'b0);

        // R10 R11: pseudo-random mode
        cur_req = "R10";
        prbs_mode = 1'b1;
        send_prbs(300);
        idle(3);
        chk("R10 lock", lb_status, 1'b1);
        cur_req = "R11";
        for (int i = 0; i < 200; i++) tick(1'b1, 1'b1, 1'b0);
        idle(3);
        chk("R11 ones", lb_status, 1'b1);
        for (int i = 0; i < 200; i++) tick(1'b0, 1'b1, 1'b0);
        idle(3);
        chk("R11 zeros", lb_status, 1'b1);
        cur_req = "R10";
        for (int i = 0; i < 200; i++) tick(1'($urandom), 1'b1, 1'b0);
        idle(3);
        chk("R10 loss", lb_status, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule